// File: doc/BRIEF.md
# Pipelined Restoring Unsigned Divider

This block divides one unsigned integer by another. It does so with a fully unrolled chain of restoring shift-and-subtract steps, one step for each quotient bit. The most significant quotient bit is settled first. Step `i` works on an (i+1)-bit window of the running remainder and compares it against the low i+1 bits of the divisor. If any divisor bit above that window is set, the step records a zero without comparing. Otherwise it subtracts whenever the window is at least the divisor slice.

Two parameters shape the block. `WIDTH` sets the operand width. `STAGE_MASK` is a WIDTH-bit mask that chooses where pipeline registers sit. Bit k places a register after the step whose subtractor is WIDTH-k bits wide, so bit 0 registers the outputs. An all-zero mask gives a purely combinational divider.

A new operation may be presented on every clock. Each result leaves the block with `ack_o` raised, a fixed number of cycles after its `valid_i`. Division by zero is not trapped.

Top module: `div_pipe`

## Requirements
- R1: When `ack_o` is high and the divisor of that operation is nonzero, `quotient_o` equals the integer quotient of the dividend by the divisor, rounded down.
- R2: When `ack_o` is high and the divisor is nonzero, `remainder_o` is below the divisor, and quotient times divisor plus remainder equals the dividend.
- R3: A zero divisor yields an all-ones quotient and a remainder equal to the dividend.
- R4: `ack_o` equals `valid_i` delayed by exactly as many clock cycles as `STAGE_MASK` has set bits. With an all-zero mask, `ack_o` follows `valid_i` in the same cycle.
- R5: Operations may be presented on consecutive cycles. Every accepted operation produces exactly one `ack_o` pulse, in the order the operations were accepted.
- R6: While `rst_ni` is low, `ack_o` of a pipelined configuration is 0. Operations in flight when reset is asserted never produce an `ack_o`.
- R7: A divisor larger than the dividend yields quotient 0 and a remainder equal to the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the pipeline valid bits only |
| valid_i | input | 1 | Operation strobe for the operands on this cycle |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| ack_o | output | 1 | Result strobe, `valid_i` delayed by the configured latency |
| quotient_o | output | WIDTH | Unsigned quotient |
| remainder_o | output | WIDTH | Unsigned remainder |

## Verification
The state hardest to reach from the ports is a reset that lands while several operations sit in different register stages. Reaching it requires a burst of back-to-back operations, then a reset pulse mid-burst, and only then a check that no stale acknowledge escapes and that fresh operations still come out correctly.

A second hard case is steps blocked by high divisor bits while the low divisor slice would still compare as smaller. Random divisors drawn with random right shifts and near-dividend values cover these steps, alongside directed zero, one and all-ones operands.

The same stream runs through a combinational, a two-stage and a four-stage instance at once.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int DEF_WIDTH = 32;
  // register boundaries after the 16-, 25- and 32-bit steps
  localparam logic [31:0] DEF_MASK = 32'h0001_0081;
  localparam int MAX_WIDTH = 128;

  function automatic int stage_count(input logic [MAX_WIDTH-1:0] mask);
    int n = 0;
    for (int k = 0; k < MAX_WIDTH; k++) n += int'(mask[k]);
    return n;
  endfunction
endpackage

// File: rtl/div_step.sv
module div_step #(
  parameter int WIDTH = 32,
  parameter int IDX   = 0
) (
  input  logic [WIDTH-1:0] work_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] work_o,
  output logic [WIDTH-1:0] quo_o
);
  localparam int SW = IDX + 1;

  logic [SW-1:0] slice, dslice, diff;
  logic blocked, take;

  assign slice  = work_i[WIDTH-1 -: SW];
  assign dslice = divisor_i[SW-1:0];

  if (SW < WIDTH) begin : g_part
    assign blocked = |divisor_i[WIDTH-1:SW];
    assign work_o  = {diff, work_i[WIDTH-SW-1:0]};
  end else begin : g_full
    assign blocked = 1'b0;
    assign work_o  = diff;
  end

  assign take = !blocked && (slice >= dslice);
  assign diff = take ? slice - dslice : slice;

  always_comb begin
    quo_o = quo_i;
    quo_o[WIDTH-1-IDX] = take;
  end
endmodule

// File: rtl/div_stage.sv
module div_stage #(
  parameter int WIDTH = 32,
  parameter bit EN    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] work_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] div_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] work_o,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] div_o
);
  if (EN) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_o <= 1'b0;
      else         vld_o <= vld_i;
    end
    // data path carries no reset
    always_ff @(posedge clk_i) begin
      work_o <= work_i;
      quo_o  <= quo_i;
      div_o  <= div_i;
    end
  end else begin : g_wire
    logic unused_clk_rst;
    assign unused_clk_rst = clk_i ^ rst_ni;
    assign vld_o  = vld_i;
    assign work_o = work_i;
    assign quo_o  = quo_i;
    assign div_o  = div_i;
  end
endmodule

// File: rtl/div_pipe.sv
module div_pipe
  import div_pkg::*;
#(
  parameter int               WIDTH      = DEF_WIDTH,
  parameter logic [WIDTH-1:0] STAGE_MASK = WIDTH'(DEF_MASK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             ack_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_it
    logic             v_in, v_out;
    logic [WIDTH-1:0] w_in, q_in, d_in;
    logic [WIDTH-1:0] w_nx, q_nx;
    logic [WIDTH-1:0] w_out, q_out, d_out;

    if (i == 0) begin : g_src
      assign v_in = valid_i;
      assign w_in = dividend_i;
      assign q_in = '0;
      assign d_in = divisor_i;
    end else begin : g_link
      assign v_in = g_it[i-1].v_out;
      assign w_in = g_it[i-1].w_out;
      assign q_in = g_it[i-1].q_out;
      assign d_in = g_it[i-1].d_out;
    end

    div_step #(.WIDTH(WIDTH), .IDX(i)) u_step (
      .work_i   (w_in),
      .quo_i    (q_in),
      .divisor_i(d_in),
      .work_o   (w_nx),
      .quo_o    (q_nx)
    );

    // mask bit k sits after the step of width WIDTH-k
    div_stage #(.WIDTH(WIDTH), .EN(STAGE_MASK[WIDTH-1-i])) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (v_in),
      .work_i(w_nx),
      .quo_i (q_nx),
      .div_i (d_in),
      .vld_o (v_out),
      .work_o(w_out),
      .quo_o (q_out),
      .div_o (d_out)
    );
  end

  assign ack_o       = g_it[WIDTH-1].v_out;
  assign quotient_o  = g_it[WIDTH-1].q_out;
  assign remainder_o = g_it[WIDTH-1].w_out;
endmodule

// File: rtl/div_pipe_chk.sv
module div_pipe_chk
  import div_pkg::*;
#(
  parameter int               WIDTH      = 32,
  parameter logic [WIDTH-1:0] STAGE_MASK = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             ack_o,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o
);
  localparam int LAT = stage_count(MAX_WIDTH'(STAGE_MASK));

  logic             vld_d [0:LAT];
  logic [WIDTH-1:0] a_d   [0:LAT];
  logic [WIDTH-1:0] b_d   [0:LAT];

  assign vld_d[0] = valid_i;
  assign a_d[0]   = dividend_i;
  assign b_d[0]   = divisor_i;

  for (genvar k = 0; k < LAT; k++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_d[k+1] <= 1'b0;
      else         vld_d[k+1] <= vld_d[k];
    end
    always_ff @(posedge clk_i) begin
      a_d[k+1] <= a_d[k];
      b_d[k+1] <= b_d[k];
    end
  end

  logic [WIDTH-1:0]   a_ref, b_ref;
  logic [2*WIDTH-1:0] recon;
  assign a_ref = a_d[LAT];
  assign b_ref = b_d[LAT];
  assign recon = {{WIDTH{1'b0}}, quotient_o} * {{WIDTH{1'b0}}, b_ref}
               + {{WIDTH{1'b0}}, remainder_o};

  // R4
  ack_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o == vld_d[LAT]);

  // R1
  quo_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && b_ref != '0) |-> quotient_o == a_ref / b_ref);

  // R2
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && b_ref != '0) |-> remainder_o < b_ref);

  // R2
  rem_recon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && b_ref != '0) |-> recon == {{WIDTH{1'b0}}, a_ref});

  // R3
  zero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && b_ref == '0) |-> (quotient_o == '1 && remainder_o == a_ref));

  // R7
  big_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && b_ref > a_ref) |-> (quotient_o == '0 && remainder_o == a_ref));

  if (LAT > 0) begin : g_rst
    // R6
    always_ff @(posedge clk_i) begin
      if (!rst_ni) rst_quiet_chk: assert (!ack_o);
    end
  end
endmodule

bind div_pipe div_pipe_chk #(.WIDTH(WIDTH), .STAGE_MASK(STAGE_MASK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .ack_o      (ack_o),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o)
);

// File: tb/tb_div_pipe.sv
module tb_div_pipe;
  localparam int W = 16;
  localparam logic [W-1:0] MASK_A = 16'h0101;  // 2 stages
  localparam logic [W-1:0] MASK_C = 16'h0000;  // combinational
  localparam logic [W-1:0] MASK_D = 16'h8421;  // 4 stages
  localparam int LAT_A = 2, LAT_C = 0, LAT_D = 4;
  localparam int HMAX = 4096;

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic ack_a, ack_c, ack_d;
  logic [W-1:0] q_a, r_a, q_c, r_c, q_d, r_d;

  always #2 clk_i = ~clk_i;

  div_pipe #(.WIDTH(W), .STAGE_MASK(MASK_A)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .dividend_i(a_i),
    .divisor_i(b_i), .ack_o(ack_a), .quotient_o(q_a), .remainder_o(r_a));
  div_pipe #(.WIDTH(W), .STAGE_MASK(MASK_C)) dut_c (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .dividend_i(a_i),
    .divisor_i(b_i), .ack_o(ack_c), .quotient_o(q_c), .remainder_o(r_c));
  div_pipe #(.WIDTH(W), .STAGE_MASK(MASK_D)) dut_d (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .dividend_i(a_i),
    .divisor_i(b_i), .ack_o(ack_d), .quotient_o(q_d), .remainder_o(r_d));

  int n_chk = 0, n_fail = 0, cyc = 0, sent = 0;
  int got_a = 0, got_c = 0, got_d = 0;
  bit done = 1'b0;
  logic         h_v [HMAX];
  logic [W-1:0] h_a [HMAX];
  logic [W-1:0] h_b [HMAX];

  function automatic logic [W-1:0] exp_quo(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b == '0) ? '1 : a / b;
  endfunction

  function automatic logic [W-1:0] exp_rem(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b == '0) ? a : a % b;
  endfunction

  function automatic string tag(input logic [W-1:0] a, input logic [W-1:0] b);
    if (b == '0) return "R3";
    if (b > a)   return "R7";
    return "R1/R2";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_dut(input int lat, input string nm, input logic ack,
                           input logic [W-1:0] q, input logic [W-1:0] r);
    int s = cyc - lat;
    logic ev = (s >= 0) ? h_v[s] : 1'b0;
    check(ack == ev, "R4", {nm, " ack"}, W'(ack), W'(ev));
    if (ev && ack) begin
      check(q == exp_quo(h_a[s], h_b[s]), tag(h_a[s], h_b[s]), {nm, " quotient"},
            q, exp_quo(h_a[s], h_b[s]));
      check(r == exp_rem(h_a[s], h_b[s]), tag(h_a[s], h_b[s]), {nm, " remainder"},
            r, exp_rem(h_a[s], h_b[s]));
    end
  endtask

  task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    valid_i = v; a_i = a; b_i = b;
    h_v[cyc] = v; h_a[cyc] = a; h_b[cyc] = b;
    if (v) sent++;
    #1;
    if (ack_a) got_a++;
    if (ack_c) got_c++;
    if (ack_d) got_d++;
    check_dut(LAT_A, "dut", ack_a, q_a, r_a);
    check_dut(LAT_C, "dut_c", ack_c, q_c, r_c);
    check_dut(LAT_D, "dut_d", ack_d, q_d, r_d);
    cyc++;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'd1357));
    for (int k = 0; k < HMAX; k++) begin
      h_v[k] = 1'b0; h_a[k] = '0; h_b[k] = '0;
    end
    repeat (3) @(negedge clk_i);
    #1;
    // R6: reset state
    check(!ack_a && !ack_d, "R6", "ack in reset", W'({ack_a, ack_d}), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed corners, back to back (R5)
    step(1, 16'h0000, 16'h0000);
    step(1, 16'h0005, 16'h0000);
    step(1, 16'hFFFF, 16'h0000);
    step(1, 16'h0000, 16'h0007);
    step(1, 16'h0001, 16'h0001);
    step(1, 16'hFFFF, 16'h0001);
    step(1, 16'hFFFF, 16'hFFFF);
    step(1, 16'h0003, 16'hFFFF);
    step(1, 16'hFFFE, 16'hFFFF);
    step(1, 16'h0007, 16'h0064);
    step(1, 16'h0064, 16'h0007);
    step(1, 16'h8000, 16'h0003);
    step(1, 16'h8001, 16'h8000);
    step(1, 16'h00FF, 16'h0100);
    step(0, 16'h0000, 16'h0000);

    for (int n = 0; n < 1500; n++) begin
      ra = W'($urandom);
      case ($urandom % 4)
        0: rb = W'($urandom);
        1: rb = W'($urandom % 16);
        2: rb = W'($urandom) >> ($urandom % 16);
        default: rb = ra + W'($urandom % 4);
      endcase
      step(($urandom % 5) != 0, ra, rb);
    end
    repeat (6) step(0, '0, '0);

    // R5: one acknowledge per accepted operation
    check(got_a == sent, "R5", "dut ack count", W'(got_a), W'(sent));
    check(got_c == sent, "R5", "dut_c ack count", W'(got_c), W'(sent));
    check(got_d == sent, "R5", "dut_d ack count", W'(got_d), W'(sent));

    // R6: reset with operations in flight
    step(1, 16'h1234, 16'h0011);
    step(1, 16'hABCD, 16'h0003);
    step(1, 16'h0F0F, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b0; valid_i = 1'b0;
    #1;
    check(!ack_a, "R6", "dut ack during reset", W'(ack_a), '0);
    check(!ack_d, "R6", "dut_d ack during reset", W'(ack_d), '0);
    for (int k = 0; k < HMAX; k++) h_v[k] = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (6) step(0, '0, '0);
    step(1, 16'h4321, 16'h0021);
    step(1, 16'h0010, 16'h0000);
    step(1, 16'h0002, 16'h0009);
    repeat (6) step(0, '0, '0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule